// File: doc/BRIEF.md
# Latched Parallel Line-Circuit Mode Controller

This block is the controller-facing side of a subscriber line circuit. A card controller selects one of several line operating modes by driving a small set of parallel mode pins while holding an active-low chip select, and the choice is latched on the chip-select rising edge. The block turns the latched choice into a decoded mode, a two-wire three-level state code for the high-voltage line driver, a power-down drive and a limit-current selection. It also reports line status back on two pins (hook state and a ground-key or DC-region flag) that are driven only while the block is selected, so many such controllers can share one set of wires.

Two of the mode pins (the ring pin and the auto pin) can also be left undriven. Each of them is modelled as a 2-bit code {driven, value}: 2'b10 means driven 0, 2'b11 means driven 1, and 2'b00 or 2'b01 means undriven. An undriven ring pin picks a ring-pause variant and an undriven auto pin picks a boosted-battery variant. Each three-level driver wire is modelled as a 2-bit signed level: 2'b01 is the positive level, 2'b00 is zero, 2'b11 is the negative level. Each tri-state output pad is modelled as a value plus an output enable. All ports are sampled on one clock, with a synchronous active-low reset.

Top module: `slic_mode_ctrl`

## Requirements
- R1: The mode pins are captured on the first clock edge at which cs_n is seen high after being low, using the last pin values sampled while cs_n was low; mode_o and lim_o change on that edge and not while cs_n is still low.
- R2: While cs_n stays high, changes on the mode pins have no effect: mode_o and lim_o hold their values.
- R3: onhk_oe_o and gdk_oe_o are 1 exactly while cs_n is 0 and 0 while cs_n is 1.
- R4: A write with pwon=1, ring driven 0, auto driven 1 gives conversation (mode_o=4) with lim_o=0 (25 mA); with auto driven 0, lim pin 1 gives lim_o=1 (40 mA) and lim pin 0 gives lim_o=2 (60 mA).
- R5: With pwon=0, ring and auto both driven: (0,0) gives standby (mode_o=1), (1,1) automatic standby (mode_o=2, pd_o=1), (1,0) power-down (mode_o=0, pd_o=1), (0,1) test (mode_o=3); pd_o is 0 in standby.
- R6: pwon=1 with ring driven 1 gives ringing (mode_o=6) and the auto/lim pins set lim_o as in R4; while ringing, an off-hook input (hook_off_i=1) switches mode_o to conversation (4) on the next edge, keeping lim_o.
- R7: pwon=1 with ring undriven and auto driven gives ring pause (mode_o=7, lim_o as in R4); pwon=1 with ring driven 0 and auto undriven gives boosted battery (mode_o=5) with lim_o forced to 0 whatever the lim pin.
- R8: The driver code (drv_a_o, drv_b_o) is (+,+) in standby, automatic standby and power-down, (+,0) in conversation, test and ring pause, (0,0) in boosted battery and (-,0) in ringing.
- R9: In conversation, gdk_o goes 0 one edge after long_ma_i exceeds 12 and returns to 1 one edge after it falls below 8; between these it holds.
- R10: In test mode, gdk_o follows dc_res_i (0 for current-limit region, 1 for resistive), and entering test mode leaves lim_o at its previous value.
- R11: While mr_n is 0, mode_o reads 0, pd_o is 1 and the driver code is (+,+); when mr_n returns to 1 the latched mode reappears.
- R12: A write with any other pin combination (pwon=0 with an undriven pin, or pwon=1 with auto undriven and ring not driven 0) leaves mode_o and lim_o unchanged.
- R13: After reset mode_o is 0 (power-down), lim_o is 0 and pd_o is 1; onhk_o is the inverse of hook_off_i (1 on-hook, 0 off-hook).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; rising edge latches the mode pins |
| pwon_i | input | 1 | Power-on mode pin |
| rng_i | input | 2 | Ring mode pin, {driven, value} |
| aut_i | input | 2 | Auto mode pin, {driven, value} |
| lim_i | input | 1 | Limit-current mode pin |
| mr_n | input | 1 | Master reset, active low, forces power-down |
| hook_off_i | input | 1 | Line off-hook status, 1 = off-hook |
| long_ma_i | input | LCUR_W | Longitudinal line current in mA |
| dc_res_i | input | 1 | DC operating region, 1 = resistive |
| mode_o | output | 3 | Decoded operating mode |
| drv_a_o | output | 2 | First driver wire level code |
| drv_b_o | output | 2 | Second driver wire level code |
| pd_o | output | 1 | Power-down drive to the line driver |
| lim_o | output | 2 | Limit current: 0 = 25, 1 = 40, 2 = 60 mA |
| onhk_o | output | 1 | Hook status pad value |
| onhk_oe_o | output | 1 | Hook status pad enable |
| gdk_o | output | 1 | Ground-key / DC-region pad value |
| gdk_oe_o | output | 1 | Ground-key / DC-region pad enable |

## Verification
A wrong mode register shows at once on mode_o, the driver code and pd_o, in the same cycle it goes wrong, while a corrupted capture shadow stays hidden until the next chip-select rising edge and then shows as the wrong mode one edge later. A wrong ground-key hysteresis state shows on gdk_o only while the block is selected and in conversation, one edge after the current crosses a threshold. The directed scenarios therefore hold chip select low through conversation and test mode, and follow every write with a check one edge after the rising edge.

// File: rtl/slic_pkg.sv
// Shared types for the line-circuit mode controller.
// Assumes: mode and limit encodings below are visible at the top ports.
package slic_pkg;

    typedef enum logic [2:0] {
        MD_PD     = 3'd0,
        MD_SBY    = 3'd1,
        MD_ASBY   = 3'd2,
        MD_TEST   = 3'd3,
        MD_CVS    = 3'd4,
        MD_BOOST  = 3'd5,
        MD_RING   = 3'd6,
        MD_RPAUSE = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        LIM_25 = 2'd0,
        LIM_40 = 2'd1,
        LIM_60 = 2'd2
    } lim_e;

    // Three-level driver wire codes (signed 2-bit)
    localparam logic [1:0] LVL_POS  = 2'b01;
    localparam logic [1:0] LVL_ZERO = 2'b00;
    localparam logic [1:0] LVL_NEG  = 2'b11;

    // One write word; tri-level pins are {driven, value}
    typedef struct packed {
        logic       pwon;
        logic [1:0] rng;
        logic [1:0] aut;
        logic       lim;
    } wr_word_t;

endpackage

// File: rtl/slic_wr_capture.sv
// Write capture: keeps a shadow of the mode pins while chip select is low
// and flags the cycle in which chip select is first seen high again.
// Assumes: cs_n is synchronous to clk.
module slic_wr_capture
    import slic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  wr_word_t din,
    output wr_word_t word_o,
    output logic     stb_o
);

    wr_word_t shadow_q;
    logic     cs_q;

    // Track chip select and sample pins only while selected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            cs_q     <= 1'b1;
        end else begin
            cs_q <= cs_n;
            if (!cs_n) shadow_q <= din;
        end
    end

    assign word_o = shadow_q;
    assign stb_o  = cs_n & ~cs_q;

endmodule

// File: rtl/slic_mode_decode.sv
// Mode decoder: maps one write word to a mode and a limit current.
// Assumes: tri-level pins use {driven, value}; ok_o is 0 for unused words.
module slic_mode_decode
    import slic_pkg::*;
(
    input  wr_word_t w,
    output logic     ok_o,
    output mode_e    mode_o,
    output logic     set_lim_o,
    output lim_e     lim_o
);

    logic rng_drv, rng_val, aut_drv, aut_val;
    lim_e conv_lim;

    assign rng_drv = w.rng[1];
    assign rng_val = w.rng[0];
    assign aut_drv = w.aut[1];
    assign aut_val = w.aut[0];

    // Conversation current chosen by the auto and lim pins
    always_comb begin
        if (aut_val)    conv_lim = LIM_25;
        else if (w.lim) conv_lim = LIM_40;
        else            conv_lim = LIM_60;
    end

    // Decode the word into a mode
    always_comb begin
        ok_o      = 1'b0;
        mode_o    = MD_PD;
        set_lim_o = 1'b0;
        lim_o     = LIM_25;
        if (w.pwon) begin
            if (!aut_drv) begin
                if (rng_drv && !rng_val) begin
                    ok_o      = 1'b1;
                    mode_o    = MD_BOOST;
                    set_lim_o = 1'b1;
                    lim_o     = LIM_25;
                end
            end else begin
                ok_o      = 1'b1;
                set_lim_o = 1'b1;
                lim_o     = conv_lim;
                if (!rng_drv)     mode_o = MD_RPAUSE;
                else if (rng_val) mode_o = MD_RING;
                else              mode_o = MD_CVS;
            end
        end else if (rng_drv && aut_drv) begin
            ok_o = 1'b1;
            case ({rng_val, aut_val})
                2'b00:   mode_o = MD_SBY;
                2'b11:   mode_o = MD_ASBY;
                2'b10:   mode_o = MD_PD;
                default: mode_o = MD_TEST;
            endcase
        end
    end

endmodule

// File: rtl/slic_gk_detect.sv
// Ground-key detector: hysteresis on the longitudinal current.
// Assumes: long_ma_i is a sampled current in mA; SET_MA > CLR_MA.
module slic_gk_detect #(
    parameter int LCUR_W = 6,
    parameter int SET_MA = 12,
    parameter int CLR_MA = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LCUR_W-1:0] long_ma_i,
    output logic              gk_o
);

    localparam logic [LCUR_W-1:0] SET_V = LCUR_W'(SET_MA);
    localparam logic [LCUR_W-1:0] CLR_V = LCUR_W'(CLR_MA);

    // Set above the upper threshold, clear below the lower one
    always_ff @(posedge clk) begin
        if (!rst_n)                 gk_o <= 1'b0;
        else if (long_ma_i > SET_V) gk_o <= 1'b1;
        else if (long_ma_i < CLR_V) gk_o <= 1'b0;
    end

endmodule

// File: rtl/slic_mode_ctrl.sv
// Top: latched parallel mode interface of a subscriber line circuit.
// Holds the mode and limit current, applies ring trip and master reset,
// and maps the mode to the driver code and the status pads.
// Assumes: all inputs synchronous to clk; pads modelled as value + enable.
module slic_mode_ctrl
    import slic_pkg::*;
#(
    parameter int LCUR_W    = 6,
    parameter int GK_SET_MA = 12,
    parameter int GK_CLR_MA = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              pwon_i,
    input  logic [1:0]        rng_i,
    input  logic [1:0]        aut_i,
    input  logic              lim_i,
    input  logic              mr_n,
    input  logic              hook_off_i,
    input  logic [LCUR_W-1:0] long_ma_i,
    input  logic              dc_res_i,
    output logic [2:0]        mode_o,
    output logic [1:0]        drv_a_o,
    output logic [1:0]        drv_b_o,
    output logic              pd_o,
    output logic [1:0]        lim_o,
    output logic              onhk_o,
    output logic              onhk_oe_o,
    output logic              gdk_o,
    output logic              gdk_oe_o
);

    wr_word_t pins, word;
    logic     wr_stb, dec_ok, dec_set_lim, gk_det;
    mode_e    dec_mode, mode_q, mode_eff;
    lim_e     dec_lim, lim_q;

    assign pins = {pwon_i, rng_i, aut_i, lim_i};

    slic_wr_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .din    (pins),
        .word_o (word),
        .stb_o  (wr_stb)
    );

    slic_mode_decode u_dec (
        .w         (word),
        .ok_o      (dec_ok),
        .mode_o    (dec_mode),
        .set_lim_o (dec_set_lim),
        .lim_o     (dec_lim)
    );

    slic_gk_detect #(
        .LCUR_W (LCUR_W),
        .SET_MA (GK_SET_MA),
        .CLR_MA (GK_CLR_MA)
    ) u_gk (
        .clk       (clk),
        .rst_n     (rst_n),
        .long_ma_i (long_ma_i),
        .gk_o      (gk_det)
    );

    // Mode and limit state: writes first, then ring trip
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_PD;
            lim_q  <= LIM_25;
        end else if (wr_stb && dec_ok) begin
            mode_q <= dec_mode;
            if (dec_set_lim) lim_q <= dec_lim;
        end else if ((mode_q == MD_RING || mode_q == MD_RPAUSE) && hook_off_i) begin
            mode_q <= MD_CVS;
        end
    end

    assign mode_eff = mr_n ? mode_q : MD_PD;

    // Driver state code and power-down drive for the effective mode
    always_comb begin
        drv_a_o = LVL_POS;
        drv_b_o = LVL_POS;
        pd_o    = 1'b0;
        case (mode_eff)
            MD_CVS, MD_TEST, MD_RPAUSE: drv_b_o = LVL_ZERO;
            MD_BOOST: begin
                drv_a_o = LVL_ZERO;
                drv_b_o = LVL_ZERO;
            end
            MD_RING: begin
                drv_a_o = LVL_NEG;
                drv_b_o = LVL_ZERO;
            end
            MD_PD, MD_ASBY: pd_o = 1'b1;
            default: ;
        endcase
    end

    // Status pad value for ground key or DC region
    always_comb begin
        case (mode_eff)
            MD_CVS:  gdk_o = ~gk_det;
            MD_TEST: gdk_o = dc_res_i;
            default: gdk_o = 1'b1;
        endcase
    end

    assign mode_o    = mode_eff;
    assign lim_o     = lim_q;
    assign onhk_o    = ~hook_off_i;
    assign onhk_oe_o = ~cs_n;
    assign gdk_oe_o  = ~cs_n;

endmodule

// File: rtl/slic_mode_ctrl_chk.sv
// Checker for the mode controller, attached by bind.
// Assumes: same encodings as the top module's requirements.
module slic_mode_ctrl_chk #(
    parameter int LCUR_W    = 6,
    parameter int GK_SET_MA = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              mr_n,
    input logic              hook_off_i,
    input logic [LCUR_W-1:0] long_ma_i,
    input logic [2:0]        mode_o,
    input logic [1:0]        lim_o,
    input logic [1:0]        drv_a_o,
    input logic [1:0]        drv_b_o,
    input logic              pd_o,
    input logic              onhk_oe_o,
    input logic              gdk_oe_o,
    input logic              gdk_o
);

    localparam logic [LCUR_W-1:0] SET_V = LCUR_W'(GK_SET_MA);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && !$past(hook_off_i) && mr_n && $past(mr_n))
        |-> ($stable(mode_o) && $stable(lim_o)));

    assert_pad_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!onhk_oe_o && !gdk_oe_o));

    assert_pad_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (onhk_oe_o && gdk_oe_o));

    assert_ring_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd6 && hook_off_i && cs_n && $past(cs_n))
        |=> (!mr_n || mode_o == 3'd4));

    assert_boost_lim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd5) |-> (lim_o == 2'd0));

    assert_ring_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd6) |-> (drv_a_o == 2'b11 && drv_b_o == 2'b00));

    assert_legal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a_o != 2'b10) && (drv_b_o == 2'b00 || drv_b_o == 2'b01));

    assert_gk_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4 && $past(long_ma_i) > SET_V) |-> !gdk_o);

    assert_master_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_n |-> (mode_o == 3'd0 && pd_o));

endmodule

bind slic_mode_ctrl slic_mode_ctrl_chk #(
    .LCUR_W    (LCUR_W),
    .GK_SET_MA (GK_SET_MA)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .mr_n       (mr_n),
    .hook_off_i (hook_off_i),
    .long_ma_i  (long_ma_i),
    .mode_o     (mode_o),
    .lim_o      (lim_o),
    .drv_a_o    (drv_a_o),
    .drv_b_o    (drv_b_o),
    .pd_o       (pd_o),
    .onhk_oe_o  (onhk_oe_o),
    .gdk_oe_o   (gdk_oe_o),
    .gdk_o      (gdk_o)
);

// File: tb/sim_slic_mode_ctrl.sv
`timescale 1ns/1ps
module sim_slic_mode_ctrl;

    localparam logic [1:0] D0 = 2'b10;
    localparam logic [1:0] D1 = 2'b11;
    localparam logic [1:0] UD = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       pwon_i = 1'b0;
    logic [1:0] rng_i = D0;
    logic [1:0] aut_i = D0;
    logic       lim_i = 1'b0;
    logic       mr_n = 1'b1;
    logic       hook_off_i = 1'b0;
    logic [5:0] long_ma_i = 6'd0;
    logic       dc_res_i = 1'b0;
    logic [2:0] mode_o;
    logic [1:0] drv_a_o, drv_b_o, lim_o;
    logic       pd_o, onhk_o, onhk_oe_o, gdk_o, gdk_oe_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    slic_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pwon_i(pwon_i),
        .rng_i(rng_i), .aut_i(aut_i), .lim_i(lim_i), .mr_n(mr_n),
        .hook_off_i(hook_off_i), .long_ma_i(long_ma_i), .dc_res_i(dc_res_i),
        .mode_o(mode_o), .drv_a_o(drv_a_o), .drv_b_o(drv_b_o), .pd_o(pd_o),
        .lim_o(lim_o), .onhk_o(onhk_o), .onhk_oe_o(onhk_oe_o),
        .gdk_o(gdk_o), .gdk_oe_o(gdk_oe_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_pins(input logic p, input logic [1:0] r,
                            input logic [1:0] a, input logic l);
        pwon_i = p; rng_i = r; aut_i = a; lim_i = l;
    endtask

    task automatic do_write(input logic p, input logic [1:0] r,
                            input logic [1:0] a, input logic l);
        @(negedge clk);
        set_pins(p, r, a, l);
        cs_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_drv(input string tag, input int a, input int b);
        chk({tag, " drv_a"}, int'(drv_a_o), a);
        chk({tag, " drv_b"}, int'(drv_b_o), b);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 reset mode", int'(mode_o), 0);
        chk("R13 reset lim", int'(lim_o), 0);
        chk("R13 reset pd", int'(pd_o), 1);
        chk("R3 reset onhk_oe", int'(onhk_oe_o), 0);
        chk_drv("R8 reset", 1, 1);
    endtask

    task automatic t_conv;
        do_write(1'b1, D0, D1, 1'b0);
        chk("R4 cvs25 mode", int'(mode_o), 4);
        chk("R4 cvs25 lim", int'(lim_o), 0);
        chk("R4 cvs25 pd", int'(pd_o), 0);
        chk_drv("R8 cvs", 1, 0);
        do_write(1'b1, D0, D0, 1'b1);
        chk("R4 cvs40 lim", int'(lim_o), 1);
        do_write(1'b1, D0, D0, 1'b0);
        chk("R4 cvs60 mode", int'(mode_o), 4);
        chk("R4 cvs60 lim", int'(lim_o), 2);
    endtask

    task automatic t_capture_edge;
        @(negedge clk);
        set_pins(1'b0, D0, D0, 1'b0);
        cs_n = 1'b0;
        @(negedge clk);
        set_pins(1'b0, D0, D1, 1'b0);
        chk("R1 no change while selected", int'(mode_o), 4);
        @(negedge clk);
        cs_n = 1'b1;
        chk("R1 no change before edge", int'(mode_o), 4);
        @(negedge clk);
        chk("R1 last value latched (test)", int'(mode_o), 3);
        chk("R10 test keeps lim", int'(lim_o), 2);
        chk_drv("R8 test", 1, 0);
    endtask

    task automatic t_ignore;
        set_pins(1'b1, D0, D1, 1'b0);
        repeat (4) @(negedge clk);
        chk("R2 mode ignored while deselected", int'(mode_o), 3);
        chk("R2 lim ignored while deselected", int'(lim_o), 2);
    endtask

    task automatic t_test_gdk;
        set_pins(1'b0, D0, D1, 1'b0);
        dc_res_i = 1'b0;
        cs_n = 1'b0;
        @(negedge clk);
        chk("R3 gdk_oe when selected", int'(gdk_oe_o), 1);
        chk("R10 gdk limit region", int'(gdk_o), 0);
        dc_res_i = 1'b1;
        @(negedge clk);
        chk("R10 gdk resistive region", int'(gdk_o), 1);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R3 gdk_oe when deselected", int'(gdk_oe_o), 0);
        chk("R3 onhk_oe when deselected", int'(onhk_oe_o), 0);
        dc_res_i = 1'b0;
    endtask

    task automatic t_standby;
        do_write(1'b0, D0, D0, 1'b0);
        chk("R5 standby mode", int'(mode_o), 1);
        chk("R5 standby pd", int'(pd_o), 0);
        chk_drv("R8 standby", 1, 1);
        do_write(1'b0, D1, D1, 1'b0);
        chk("R5 auto standby mode", int'(mode_o), 2);
        chk("R5 auto standby pd", int'(pd_o), 1);
        do_write(1'b0, D1, D0, 1'b0);
        chk("R5 power-down mode", int'(mode_o), 0);
        chk("R5 power-down pd", int'(pd_o), 1);
    endtask

    task automatic t_gdk_hyst;
        do_write(1'b1, D0, D1, 1'b0);
        chk("R4 cvs25 again", int'(mode_o), 4);
        cs_n = 1'b0;
        long_ma_i = 6'd10;
        @(negedge clk);
        chk("R9 gdk idle at 10", int'(gdk_o), 1);
        long_ma_i = 6'd13;
        @(negedge clk);
        chk("R9 gdk set above 12", int'(gdk_o), 0);
        long_ma_i = 6'd10;
        @(negedge clk);
        chk("R9 gdk holds at 10", int'(gdk_o), 0);
        long_ma_i = 6'd7;
        @(negedge clk);
        chk("R9 gdk clears below 8", int'(gdk_o), 1);
        long_ma_i = 6'd0;
        hook_off_i = 1'b0;
        @(negedge clk);
        chk("R13 onhk on-hook", int'(onhk_o), 1);
        hook_off_i = 1'b1;
        @(negedge clk);
        chk("R13 onhk off-hook", int'(onhk_o), 0);
        chk("R3 onhk_oe when selected", int'(onhk_oe_o), 1);
        hook_off_i = 1'b0;
        cs_n = 1'b1;
        @(negedge clk);
        chk("R6 no trip outside ringing", int'(mode_o), 4);
    endtask

    task automatic t_ring;
        do_write(1'b1, D1, D0, 1'b0);
        chk("R6 ringing mode", int'(mode_o), 6);
        chk("R6 ringing lim", int'(lim_o), 2);
        chk_drv("R8 ringing", 3, 0);
        hook_off_i = 1'b1;
        @(negedge clk);
        chk("R6 ring trip to conversation", int'(mode_o), 4);
        chk("R6 ring trip keeps lim", int'(lim_o), 2);
        hook_off_i = 1'b0;
    endtask

    task automatic t_variants;
        do_write(1'b1, UD, D1, 1'b1);
        chk("R7 ring pause mode", int'(mode_o), 7);
        chk("R7 ring pause lim", int'(lim_o), 0);
        chk_drv("R8 ring pause", 1, 0);
        do_write(1'b1, D0, D0, 1'b0);
        chk("R4 cvs60 before boost", int'(lim_o), 2);
        do_write(1'b1, D0, UD, 1'b0);
        chk("R7 boost mode", int'(mode_o), 5);
        chk("R7 boost lim forced 25", int'(lim_o), 0);
        chk_drv("R8 boost", 0, 0);
    endtask

    task automatic t_undef;
        do_write(1'b0, UD, D1, 1'b0);
        chk("R12 undefined pwon0 mode", int'(mode_o), 5);
        do_write(1'b1, D1, UD, 1'b1);
        chk("R12 undefined ring+auto-undriven mode", int'(mode_o), 5);
        chk("R12 undefined lim", int'(lim_o), 0);
    endtask

    task automatic t_master;
        @(negedge clk);
        mr_n = 1'b0;
        @(negedge clk);
        chk("R11 master reset mode", int'(mode_o), 0);
        chk("R11 master reset pd", int'(pd_o), 1);
        chk_drv("R11 master reset", 1, 1);
        mr_n = 1'b1;
        @(negedge clk);
        chk("R11 latched mode returns", int'(mode_o), 5);
        chk("R11 pd released", int'(pd_o), 0);
    endtask

    initial begin
        t_reset();
        t_conv();
        t_capture_edge();
        t_ignore();
        t_test_gdk();
        t_standby();
        t_gdk_hyst();
        t_ring();
        t_variants();
        t_undef();
        t_master();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule